// File: doc/BRIEF.md
# In-Order Issue Queue

This block holds dispatched instructions for an execution pipeline that must see its work in strict program order, such as control-register and system operations. Each cycle the frontend may offer a group of up to four instructions across parallel lanes. The queue stores them in a small circular buffer, lower lanes first. A group is taken only if every valid lane in it fits.

Each stored instruction carries two source operand tags and a ready bit for each. At dispatch the ready bits come from the frontend's ready-table lookup, and a writeback bus tag seen in the same cycle can also set them. After dispatch a matching tag on the writeback bus sets them. Only the oldest entry may issue, and only once both of its operands are ready. A ready younger entry never issues ahead of a stalled head. The head may issue in the same cycle that its last operand is written back. The downstream pipeline applies backpressure through a valid/ready handshake, and the head leaves the queue only when that handshake completes.

Top module: `inorder_iq`

## Requirements
- R1: Reset empties the queue. While reset is held and afterwards, `iss_valid` is 0 and `disp_ready` is 1 for any group of at most 4 lanes.
- R2: `disp_ready` is 1 exactly when the number of set bits in `disp_valid` is no more than 4 minus the current occupancy. When it is 0, no lane of the group is stored.
- R3: The valid lanes of an accepted group enter the queue in lane order, lane 0 being oldest, with empty lanes skipped. Issue follows that order across groups.
- R4: Only the oldest entry can issue. While its operands are not both ready, `iss_valid` is 0 even if younger entries are ready.
- R5: At dispatch each operand's ready bit is taken from the lane's ready-table input. A 0 bit leaves the operand waiting.
- R6: An operand whose tag equals `wb_tag` while `wb_valid` is 1 in its dispatch cycle is stored as ready.
- R7: A stored waiting operand becomes ready when `wb_valid` is 1 with an equal `wb_tag`. A writeback with a different tag leaves it waiting.
- R8: When the head's last waiting operand is written back, `iss_valid` rises in that same cycle, with `iss_op` showing the head.
- R9: The head advances only in a cycle with `iss_valid` and `iss_ready` both 1. While `iss_ready` is 0, `iss_valid` stays 1 and `iss_op` holds.
- R10: Dispatch and issue in the same cycle change occupancy by the group size minus one. The queue can fill to exactly 4 entries and drain to empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 4 | Per-lane dispatch valid, lane 0 oldest |
| disp_op | input | 32 | Per-lane instruction payload, 8 bits per lane, lane i at [8i+7:8i] |
| disp_a_tag | input | 24 | Per-lane first source tag, 6 bits per lane |
| disp_b_tag | input | 24 | Per-lane second source tag, 6 bits per lane |
| disp_a_rdy | input | 4 | Per-lane ready-table bit for the first source |
| disp_b_rdy | input | 4 | Per-lane ready-table bit for the second source |
| disp_ready | output | 1 | Whole group fits and is taken this cycle |
| wb_valid | input | 1 | Writeback bus valid |
| wb_tag | input | 6 | Writeback bus destination tag |
| iss_valid | output | 1 | Head entry is ready to issue |
| iss_ready | input | 1 | Downstream pipeline accepts the head |
| iss_op | output | 8 | Payload of the head entry |

## Verification
The hardest situation to reach is a stalled head with a ready younger entry behind it, followed by a head wakeup that arrives in the same cycle as an issue handshake. The stimulus dispatches a two-lane group in which only the younger lane is ready. It holds the bus idle for a cycle to show the block, then drives the head's tag on the writeback bus with `iss_ready` high. A second sequence fills all four slots under backpressure. It then offers groups that do not fit while the head drains one entry per cycle, so that rejection, the same-cycle count update and the issue order are all seen at the boundary.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_DEPTH = 4;
  localparam int IQ_LANES = 4;
  localparam int IQ_TAG_W = 6;
  localparam int IQ_OP_W  = 8;
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int TAG_W = 6
) (
  input  logic             rdy_in,
  input  logic [TAG_W-1:0] tag,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             rdy_out
);
  // A pending operand turns ready when the writeback bus carries its tag.
  assign rdy_out = rdy_in | (wb_valid && (wb_tag == tag));
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int LANES = 4,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LCW   = $clog2(LANES + 1)
) (
  input  logic [PTR_W-1:0]            tail,
  input  logic [LANES-1:0]            lane_valid,
  output logic [LANES-1:0][PTR_W-1:0] slot,
  output logic [LCW-1:0]              grp_size
);
  // Compact the valid lanes onto consecutive slots starting at the tail.
  logic [LCW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      slot[i] = tail + PTR_W'(acc);
      acc     = acc + LCW'(lane_valid[i]);
    end
    grp_size = acc;
  end
endmodule

// File: rtl/inorder_iq.sv
module inorder_iq
  import iq_pkg::*;
#(
  parameter int DEPTH = IQ_DEPTH,
  parameter int LANES = IQ_LANES,
  parameter int TAG_W = IQ_TAG_W,
  parameter int OP_W  = IQ_OP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       disp_valid,
  input  logic [LANES*OP_W-1:0]  disp_op,
  input  logic [LANES*TAG_W-1:0] disp_a_tag,
  input  logic [LANES*TAG_W-1:0] disp_b_tag,
  input  logic [LANES-1:0]       disp_a_rdy,
  input  logic [LANES-1:0]       disp_b_rdy,
  output logic                   disp_ready,
  input  logic                   wb_valid,
  input  logic [TAG_W-1:0]       wb_tag,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic [OP_W-1:0]        iss_op
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LCW   = $clog2(LANES + 1);
  localparam int SW    = ((LCW > CNT_W) ? LCW : CNT_W) + 1;

  // Pointers and occupancy
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  // Entry state: control bits are reset, payload storage is not
  logic [DEPTH-1:0] e_vld, e_ardy, e_brdy;
  logic [DEPTH-1:0] e_ardy_nxt, e_brdy_nxt;
  logic [TAG_W-1:0] e_atag [DEPTH];
  logic [TAG_W-1:0] e_btag [DEPTH];
  logic [OP_W-1:0]  e_op   [DEPTH];

  // Dispatch-side readiness per lane
  logic [LANES-1:0] l_ardy, l_brdy;
  logic [LANES-1:0][PTR_W-1:0] slot;
  logic [LCW-1:0] grp;
  logic [SW-1:0]  free_w;
  logic           accept, fire;

  iq_alloc #(.LANES(LANES), .DEPTH(DEPTH)) u_alloc (
    .tail      (tail),
    .lane_valid(disp_valid),
    .slot      (slot),
    .grp_size  (grp)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    iq_wakeup #(.TAG_W(TAG_W)) u_la (
      .rdy_in  (disp_a_rdy[i]),
      .tag     (disp_a_tag[i*TAG_W +: TAG_W]),
      .wb_valid(wb_valid),
      .wb_tag  (wb_tag),
      .rdy_out (l_ardy[i])
    );
    iq_wakeup #(.TAG_W(TAG_W)) u_lb (
      .rdy_in  (disp_b_rdy[i]),
      .tag     (disp_b_tag[i*TAG_W +: TAG_W]),
      .wb_valid(wb_valid),
      .wb_tag  (wb_tag),
      .rdy_out (l_brdy[i])
    );
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    iq_wakeup #(.TAG_W(TAG_W)) u_ea (
      .rdy_in  (e_ardy[j]),
      .tag     (e_atag[j]),
      .wb_valid(wb_valid),
      .wb_tag  (wb_tag),
      .rdy_out (e_ardy_nxt[j])
    );
    iq_wakeup #(.TAG_W(TAG_W)) u_eb (
      .rdy_in  (e_brdy[j]),
      .tag     (e_btag[j]),
      .wb_valid(wb_valid),
      .wb_tag  (wb_tag),
      .rdy_out (e_brdy_nxt[j])
    );
  end

  // Whole-group admission against the space left before this cycle's issue
  assign free_w     = SW'(DEPTH) - SW'(count);
  assign disp_ready = SW'(grp) <= free_w;
  assign accept     = disp_ready && (|disp_valid);

  // Head-only selection; a same-cycle writeback counts toward readiness
  assign iss_valid = e_vld[head] && e_ardy_nxt[head] && e_brdy_nxt[head];
  assign iss_op    = e_op[head];
  assign fire      = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      e_vld  <= '0;
      e_ardy <= '0;
      e_brdy <= '0;
    end else begin
      e_ardy <= e_ardy_nxt;
      e_brdy <= e_brdy_nxt;
      if (fire) begin
        e_vld[head] <= 1'b0;
        head        <= head + PTR_W'(1);
      end
      if (accept) begin
        for (int i = 0; i < LANES; i++) begin
          if (disp_valid[i]) begin
            e_vld[slot[i]]  <= 1'b1;
            e_ardy[slot[i]] <= l_ardy[i];
            e_brdy[slot[i]] <= l_brdy[i];
          end
        end
        tail <= tail + PTR_W'(grp);
      end
      count <= count + (accept ? CNT_W'(grp) : '0) - CNT_W'(fire);
    end
  end

  // Payload and tag storage, written only at dispatch
  always_ff @(posedge clk) begin
    if (!rst && accept) begin
      for (int i = 0; i < LANES; i++) begin
        if (disp_valid[i]) begin
          e_op[slot[i]]   <= disp_op[i*OP_W +: OP_W];
          e_atag[slot[i]] <= disp_a_tag[i*TAG_W +: TAG_W];
          e_btag[slot[i]] <= disp_b_tag[i*TAG_W +: TAG_W];
        end
      end
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int DEPTH = 4,
  parameter int LANES = 4,
  parameter int OP_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] disp_valid,
  input logic             disp_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [OP_W-1:0]  iss_op
);
  // Occupancy rebuilt from port traffic only
  logic [7:0] mcnt;
  always_ff @(posedge clk) begin
    if (rst) mcnt <= '0;
    else mcnt <= mcnt + (disp_ready ? 8'($countones(disp_valid)) : 8'd0)
                      - 8'(iss_valid && iss_ready);
  end

  // R1: the cycle after reset shows nothing to issue
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !iss_valid);

  // R2: admission matches the space left
  a_r2_group_fits: assert property (@(posedge clk) disable iff (rst)
    disp_ready == ($countones(disp_valid) <= (DEPTH - int'(mcnt))));

  // R10: occupancy never exceeds the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(mcnt) <= DEPTH);

  // R4: an empty queue never offers an instruction
  a_r4_empty_idle: assert property (@(posedge clk) disable iff (rst)
    (mcnt == 8'd0) |-> !iss_valid);

  // R9: a stalled head stays offered and unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op)));
endmodule

bind inorder_iq iq_checker #(.DEPTH(DEPTH), .LANES(LANES), .OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_op    (iss_op)
);

// File: tb/inorder_iq_tb.sv
module inorder_iq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  disp_valid = '0;
  logic [31:0] disp_op = '0;
  logic [23:0] disp_a_tag = '0, disp_b_tag = '0;
  logic [3:0]  disp_a_rdy = '0, disp_b_rdy = '0;
  logic        disp_ready;
  logic        wb_valid = 1'b0;
  logic [5:0]  wb_tag = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [7:0]  iss_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inorder_iq u_dut (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a_tag(disp_a_tag), .disp_b_tag(disp_b_tag),
    .disp_a_rdy(disp_a_rdy), .disp_b_rdy(disp_b_rdy),
    .disp_ready(disp_ready),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op)
  );

  typedef struct packed {
    logic [3:0]  dv;
    logic [31:0] op;
    logic [23:0] atag;
    logic [3:0]  ardy;
    logic [3:0]  brdy;
    logic        wbv;
    logic [5:0]  wbt;
    logic        irdy;
    logic        edr;
    logic        eiv;
    logic [7:0]  eiop;
  } vec_t;

  // Second-source tags are all 63 in the table; the bus never carries 63 there.
  localparam vec_t VECS [10] = '{
    // 0 R3 R5: two lanes; lane0 waits on tag 5, lane1 ready from table
    '{4'b0011, 32'h0000_1110, {6'd0,6'd0,6'd0,6'd5}, 4'b0010, 4'b1111, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 8'h00},
    // 1 R4: head waits, ready younger entry is blocked
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 8'h00},
    // 2 R8: writeback of tag 5 issues head in the same cycle
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b1, 6'd5, 1'b1, 1'b1, 1'b1, 8'h10},
    // 3 R9: backpressure, head held
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 8'h11},
    // 4 R9: still held
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 8'h11},
    // 5 R2: group of four with one entry present is refused
    '{4'b1111, 32'h5555_5555, 24'h0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 8'h11},
    // 6 R2 R6: queue empty (refused group not stored); lanes 1 and 3, tag 7 written back now
    '{4'b1010, 32'h2300_2100, {6'd0,6'd0,6'd7,6'd0}, 4'b1000, 4'b1111, 1'b1, 6'd7, 1'b1, 1'b1, 1'b0, 8'h00},
    // 7 R3 R6: lane1 entry first, ready from same-cycle writeback
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b1, 1'b1, 1'b1, 8'h21},
    // 8 R3: lane3 entry next
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b1, 1'b1, 1'b1, 8'h23},
    // 9 R10: drained
    '{4'b0000, 32'h0, 24'h0, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] dv, input logic [31:0] op,
                       input logic [23:0] at, input logic [23:0] bt,
                       input logic [3:0] ar, input logic [3:0] br,
                       input logic wv, input logic [5:0] wt, input logic ir);
    @(negedge clk);
    disp_valid = dv; disp_op = op; disp_a_tag = at; disp_b_tag = bt;
    disp_a_rdy = ar; disp_b_rdy = br; wb_valid = wv; wb_tag = wt; iss_ready = ir;
    #1;
  endtask

  task automatic expect_out(input string req, input logic edr,
                            input logic eiv, input logic [7:0] eop);
    chk(req, "disp_ready", 32'(disp_ready), 32'(edr));
    chk(req, "iss_valid", 32'(iss_valid), 32'(eiv));
    if (eiv) chk(req, "iss_op", 32'(iss_op), 32'(eop));
  endtask

  initial begin
    // R1: reset state, full group offered while reset is held
    drive(4'b1111, 32'hEEEE_EEEE, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b1);
    expect_out("R1", 1'b1, 1'b0, 8'h00);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    rst = 1'b0;
    #1;
    expect_out("R1", 1'b1, 1'b0, 8'h00);

    // Table walk
    for (int k = 0; k < 10; k++) begin
      drive(VECS[k].dv, VECS[k].op, VECS[k].atag, 24'hFFFFFF,
            VECS[k].ardy, VECS[k].brdy, VECS[k].wbv, VECS[k].wbt, VECS[k].irdy);
      expect_out($sformatf("table%0d", k), VECS[k].edr, VECS[k].eiv, VECS[k].eiop);
    end

    // R10: fill to four under backpressure, then dispatch while draining
    drive(4'b1111, 32'h3332_3130, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b0);
    expect_out("R10", 1'b1, 1'b0, 8'h00);
    drive(4'b0001, 32'h34, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b0);
    expect_out("R2", 1'b0, 1'b1, 8'h30);
    drive(4'b0001, 32'h34, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b1);
    expect_out("R2", 1'b0, 1'b1, 8'h30);
    drive(4'b0001, 32'h35, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b1);
    expect_out("R10", 1'b1, 1'b1, 8'h31);
    drive(4'b0011, 32'h3736, '0, '0, 4'b1111, 4'b1111, 1'b0, 6'd0, 1'b1);
    expect_out("R10", 1'b0, 1'b1, 8'h32);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    expect_out("R3", 1'b1, 1'b1, 8'h33);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    expect_out("R3", 1'b1, 1'b1, 8'h35);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    expect_out("R10", 1'b1, 1'b0, 8'h00);

    // R5 R7: both sources wait (tags 9 and 10), unrelated tag ignored
    drive(4'b0001, 32'h40, 24'd9, 24'd10, 4'b0000, 4'b0000, 1'b0, 6'd0, 1'b1);
    expect_out("R5", 1'b1, 1'b0, 8'h00);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b1, 6'd11, 1'b1);
    expect_out("R7", 1'b1, 1'b0, 8'h00);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b1, 6'd9, 1'b1);
    expect_out("R5", 1'b1, 1'b0, 8'h00);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    expect_out("R7", 1'b1, 1'b0, 8'h00);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b1, 6'd10, 1'b1);
    expect_out("R8", 1'b1, 1'b1, 8'h40);
    drive(4'b0000, '0, '0, '0, '0, '0, 1'b0, 6'd0, 1'b1);
    expect_out("R9", 1'b1, 1'b0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule